// File: doc/BRIEF.md
# Stream-Fed Word Read Master

This block converts a stream of word addresses into single classic Wishbone read cycles and returns each word it reads as a token on an output stream. Both streams use valid/ready handshakes, so either side may apply backpressure. An upstream producer pushes 30-bit word addresses. A downstream consumer receives 32-bit data words in the same order as the addresses that produced them.

At most one bus cycle is outstanding at any time. The next address is taken in the same cycle that the current cycle is acknowledged, and the data just read is pushed into a small output queue of `BUF_DEPTH` entries. A new bus cycle starts only if the queue has a free slot reserved for its data. Data that the slave has acknowledged is therefore never lost. With a zero-wait slave and a consumer that is always ready, one word moves through the block every clock. Throughput drops only when the slave inserts wait states.

Top module: `wbrd_stream_reader`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drops `wb_cyc_o`, `wb_stb_o` and `out_valid`. With `out_ready` low, `in_ready` reads high afterwards.
- R2: For each accepted input token, the block drives a read cycle starting at the next clock edge. In that cycle `wb_adr_o` equals the token's word address with no byte-offset bits, `wb_we_o` is 0 and `wb_sel_o` is 4'b1111.
- R3: Once a bus cycle starts, `wb_cyc_o` and `wb_stb_o` stay high and `wb_adr_o` stays unchanged until a clock edge at which `wb_ack_i` is high.
- R4: Each accepted token causes exactly one acknowledged read. There is never more than one bus cycle outstanding.
- R5: Each output token carries the value of `wb_dat_i` sampled on the acknowledge edge of the matching read. Output tokens appear in the order in which the addresses were accepted.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged. An acknowledged word is never dropped.
- R7: `in_ready` is high only when no bus cycle is pending, or the pending cycle is acknowledged in that same cycle. In both cases the output queue must also have room after this cycle's push and pop.
- R8: With a slave that acknowledges in the first cycle of each read, an always-valid input and an always-ready output, the block accepts one token per clock.
- R9: With `out_ready` held low, the block accepts exactly `BUF_DEPTH` tokens (2 by default). It then holds `in_ready` low and starts no further bus cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Address token valid |
| in_ready | output | 1 | Block can take an address token |
| in_addr | input | 30 | Word address of the read |
| wb_cyc_o | output | 1 | Bus cycle in progress |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Write enable, always 0 |
| wb_sel_o | output | 4 | Byte selects, all set during a read |
| wb_adr_o | output | 30 | Word address on the bus |
| wb_dat_i | input | 32 | Read data from the slave |
| wb_ack_i | input | 1 | Slave acknowledge |
| out_valid | output | 1 | Data token valid |
| out_ready | input | 1 | Consumer takes a data token |
| out_data | output | 32 | Word read from the bus |

## Verification
The embedded properties assume that the slave raises `wb_ack_i` only while a cycle is open. They also assume that the producer keeps `in_valid` and `in_addr` steady until the token is taken. The bench's slave model acknowledges only after it has seen a cycle for a chosen number of wait states, and it drops the acknowledge as soon as that acknowledge has been consumed. The producer side holds an unaccepted token unchanged and draws a new address only after a handshake. Wait-state counts of 0 to 3 are swept against several valid and ready densities.

// File: rtl/wbrd_pkg.sv
package wbrd_pkg;

  // Queue occupancy after one cycle of pushes and pops.
  function automatic int occ_next(input int occ, input logic push, input logic pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

  // A new read may be issued when its data is guaranteed a slot.
  function automatic logic has_room(input int occ_after, input int depth);
    return occ_after < depth;
  endfunction

  // Wrap-around pointer increment for a queue of arbitrary depth.
  function automatic int ptr_inc(input int p, input int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/wbrd_bus_issue.sv
module wbrd_bus_issue #(
  parameter int AW = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_adr,
  input  logic          ack_in,
  output logic          pend,
  output logic [AW-1:0] adr,
  output logic          ack_ev
);

  assign ack_ev = pend & ack_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else if (start) begin
      pend <= 1'b1;
    end else if (ack_ev) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (start) adr <= start_adr;
  end

  // R3: an open cycle without acknowledge keeps going with the same address
  a_r3_hold_cycle: assert property (@(posedge clk) disable iff (rst)
    pend && !ack_in |=> pend && $stable(adr));

  // R4: a new cycle starts only when none remains outstanding
  a_r4_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    start |-> (!pend || ack_ev));

  // R2: the cycle after a start carries the requested address
  a_r2_start_addr: assert property (@(posedge clk) disable iff (rst)
    start |=> pend && adr == $past(start_adr));

endmodule

// File: rtl/wbrd_fifo.sv
module wbrd_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [DW-1:0]              din,
  input  logic                       pop,
  output logic                       valid,
  output logic [DW-1:0]              dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  import wbrd_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  assign valid = (count != '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= PW'(ptr_inc(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PW'(ptr_inc(int'(rd_ptr), DEPTH));
      count <= CW'(occ_next(int'(count), push, pop));
    end
  end

  // R6: an acknowledged word always finds a free slot
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push && !pop |-> int'(count) < DEPTH);

  // R6: a held output token keeps its value
  a_r6_hold_output: assert property (@(posedge clk) disable iff (rst)
    valid && !pop |=> valid && $stable(dout));

  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> valid);

endmodule

// File: rtl/wbrd_stream_reader.sv
module wbrd_stream_reader #(
  parameter int AW        = 30,
  parameter int DW        = 32,
  parameter int BUF_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  output logic          wb_cyc_o,
  output logic          wb_stb_o,
  output logic          wb_we_o,
  output logic [DW/8-1:0] wb_sel_o,
  output logic [AW-1:0] wb_adr_o,
  input  logic [DW-1:0] wb_dat_i,
  input  logic          wb_ack_i,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  import wbrd_pkg::*;

  localparam int CW = $clog2(BUF_DEPTH + 1);

  logic          pend, ack_ev, in_fire, out_pop, bus_free;
  logic [CW-1:0] occ;
  int            occ_after;

  assign out_pop   = out_valid & out_ready;
  assign occ_after = occ_next(int'(occ), ack_ev, out_pop);
  assign bus_free  = !pend || ack_ev;
  assign in_ready  = bus_free && has_room(occ_after, BUF_DEPTH);
  assign in_fire   = in_valid & in_ready;

  wbrd_bus_issue #(.AW(AW)) u_issue (
    .clk       (clk),
    .rst       (rst),
    .start     (in_fire),
    .start_adr (in_addr),
    .ack_in    (wb_ack_i),
    .pend      (pend),
    .adr       (wb_adr_o),
    .ack_ev    (ack_ev)
  );

  wbrd_fifo #(.DW(DW), .DEPTH(BUF_DEPTH)) u_queue (
    .clk   (clk),
    .rst   (rst),
    .push  (ack_ev),
    .din   (wb_dat_i),
    .pop   (out_pop),
    .valid (out_valid),
    .dout  (out_data),
    .count (occ)
  );

  assign wb_cyc_o = pend;
  assign wb_stb_o = pend;
  assign wb_we_o  = 1'b0;
  assign wb_sel_o = '1;

  // R7: the input is taken only when the bus is free or finishing
  a_r7_ready_bus: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (!wb_cyc_o || wb_ack_i));

  // R9: a full, stalled queue blocks new tokens
  a_r9_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (int'(occ) == BUF_DEPTH) && !out_ready |-> !in_ready);

  // R5: an acknowledge always produces a valid output next cycle
  a_r5_ack_to_out: assert property (@(posedge clk) disable iff (rst)
    wb_cyc_o && wb_ack_i |=> out_valid);

  // R1: the cycle after reset is idle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> !wb_cyc_o && !out_valid);

endmodule

// File: tb/wbrd_stream_reader_tb.sv
module wbrd_stream_reader_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [29:0] in_addr = '0;
  logic        wb_cyc_o, wb_stb_o, wb_we_o;
  logic [3:0]  wb_sel_o;
  logic [29:0] wb_adr_o;
  logic [31:0] wb_dat_i;
  logic        wb_ack_i = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  wbrd_stream_reader u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o),
    .wb_we_o(wb_we_o), .wb_sel_o(wb_sel_o), .wb_adr_o(wb_adr_o),
    .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [31:0] mem_word(input logic [29:0] a);
    return ({2'b00, a} * 32'h9E37_79B1) + 32'h1234_5678;
  endfunction

  assign wb_dat_i = mem_word(wb_adr_o);

  logic [29:0] expq[$];
  logic [29:0] cur_adr = '0;
  logic [29:0] tok_seq = '0;
  int          wait_n = 0;
  int          wcnt = 0;
  int          n_tok = 0;
  int          n_ack = 0;
  int          n_fire_phase = 0;
  logic        fired = 1'b0;
  logic        hold_prev = 1'b0;
  logic [31:0] hold_data = '0;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic pick(input int mode);
    case (mode)
      0: return 1'b1;
      1: return ($urandom_range(0, 1) == 0);
      2: return ($urandom_range(0, 3) == 0);
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input int vmode, input int rmode);
    @(negedge clk);
    if (wb_ack_i) begin wb_ack_i = 1'b0; wcnt = 0; end
    if (wb_cyc_o) begin
      if (wcnt >= wait_n) wb_ack_i = 1'b1;
      else wcnt++;
    end
    if (wb_cyc_o) begin
      // R2, R3: address, direction and selects of the open cycle
      chk(wb_adr_o == cur_adr && wb_stb_o && !wb_we_o && wb_sel_o == 4'hF,
          "R2/R3 bus", {2'b00, wb_adr_o}, {2'b00, cur_adr});
    end
    if (!(in_valid && !fired)) begin
      in_valid = pick(vmode);
      if (in_valid) begin
        tok_seq = tok_seq + 30'd1;
        in_addr = (tok_seq[0]) ? ~(tok_seq * 30'h0123_457) : tok_seq * 30'h0777_001;
      end
    end
    out_ready = pick(rmode);
    #1;
    if (in_ready && wb_cyc_o && !wb_ack_i)
      chk(1'b0, "R7 ready while busy", 32'(in_ready), 32'd0);
    if (hold_prev)
      chk(out_valid && out_data == hold_data, "R6 hold", out_data, hold_data);
    fired = in_valid && in_ready;
    if (fired) begin
      expq.push_back(in_addr);
      cur_adr = in_addr;
      n_tok++;
      n_fire_phase++;
    end
    if (out_valid && out_ready) begin
      if (expq.size() == 0) chk(1'b0, "R5 spurious", out_data, 32'd0);
      else begin
        logic [29:0] a;
        a = expq.pop_front();
        chk(out_data == mem_word(a), "R5 data/order", out_data, mem_word(a));
      end
    end
    if (wb_ack_i && wb_cyc_o) n_ack++;
    hold_prev = out_valid && !out_ready;
    hold_data = out_data;
  endtask

  task automatic drain();
    for (int i = 0; i < 300; i++) begin
      if (expq.size() == 0 && !wb_cyc_o && !(in_valid && !fired)) break;
      step(3, 0);
    end
    chk(expq.size() == 0 && !wb_cyc_o, "R4/R5 drained", 32'(expq.size()), 32'd0);
    chk(n_ack == n_tok, "R4 one read per token", 32'(n_ack), 32'(n_tok));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: idle state after reset
    chk(!wb_cyc_o && !wb_stb_o && !out_valid && in_ready, "R1 reset state",
        {28'd0, wb_cyc_o, wb_stb_o, out_valid, in_ready}, 32'd1);

    for (int w = 0; w < 4; w++) begin
      for (int vm = 0; vm < 3; vm++) begin
        for (int rm = 0; rm < 3; rm++) begin
          wait_n = w;
          for (int s = 0; s < 60; s++) step(vm, rm);
          drain();
        end
      end
    end

    // R8: zero-wait slave, full throughput
    wait_n = 0;
    n_fire_phase = 0;
    for (int s = 0; s < 40; s++) step(0, 0);
    chk(n_fire_phase >= 39, "R8 throughput", 32'(n_fire_phase), 32'd39);
    drain();

    // R9: stalled consumer accepts only the queue depth
    n_fire_phase = 0;
    for (int s = 0; s < 12; s++) step(0, 3);
    chk(n_fire_phase == 2, "R9 accepted count", 32'(n_fire_phase), 32'd2);
    chk(!wb_cyc_o && !in_ready, "R9 blocked", {30'd0, wb_cyc_o, in_ready}, 32'd0);
    drain();

    // R1: reset during activity returns to idle
    for (int s = 0; s < 5; s++) step(0, 3);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; wb_ack_i = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!wb_cyc_o && !out_valid && in_ready, "R1 mid-run reset",
        {29'd0, wb_cyc_o, out_valid, in_ready}, 32'd1);

    finish_run();
  end

endmodule